// File: doc/BRIEF.md
# Three-Operand Integer Multiply-Accumulate Unit

This unit executes the integer multiply-add family of a 64-bit processor. It accepts one 32-bit instruction word per cycle with a valid strobe. From that word it derives the destination index, three source indices and a 7-bit operation code. The code is formed from the size bit (31), the two bits at 30:29, the three bits at 23:21 and the subtract bit (15), in that order, most significant first. The source indices go straight out to a register-read port, and the three 64-bit operand values are expected back in the same cycle.

Depending on the operation code, the unit computes one of three things. The first is a full-width multiply followed by an add to or subtract from the accumulator operand. The second is a 32x32 widening multiply, signed or unsigned, followed by the same accumulate step. The third is the upper half of a signed or unsigned 128-bit product. The 32-bit forms return their result truncated to 32 bits and zero-extended. Register index 31 reads as zero in every source position and discards the write in the destination position, so an add with the accumulator at index 31 is a plain multiply. Any word outside the legal set raises an illegal-encoding flag in place of a write.

The result leaves as a write-back index, a 64-bit value, a write enable and the illegal flag, all qualified by a result-valid strobe. With the default parameters the strobe rises a fixed two cycles after the instruction strobe.

Top module: `mac3_unit`

## Requirements
- R1: The read indices on the register-read port are combinational copies of the instruction fields: bits 9:5 for the first factor, bits 20:16 for the second factor and bits 14:10 for the accumulator. The destination index comes from bits 4:0 and appears on the write-back index.
- R2: The operation code is {bit31, bits30:29, bits23:21, bit15}. Only 0x00, 0x01, 0x40, 0x41, 0x42, 0x43, 0x44, 0x4A, 0x4B and 0x4C are legal. Any other code raises the illegal flag with the write enable low.
- R3: An instruction whose bits 28:24 differ from 5'b11011 raises the illegal flag with the write enable low, whatever its operation code.
- R4: Codes 0x40 (add) and 0x41 (subtract) produce the accumulator plus or minus the low 64 bits of the full 64x64 product.
- R5: Codes 0x00 and 0x01 compute the same add or subtract, then deliver the low 32 bits zero-extended to 64, so the upper half of the result is zero.
- R6: Codes 0x42 (add) and 0x43 (subtract) sign-extend the low 32 bits of both factors to 64 bits, multiply them, and accumulate.
- R7: Codes 0x4A (add) and 0x4B (subtract) zero-extend the low 32 bits of both factors to 64 bits, multiply them, and accumulate.
- R8: Code 0x44 returns bits 127:64 of the signed 128-bit product, and 0x4C returns bits 127:64 of the unsigned product. The accumulator operand has no effect on either.
- R9: A source index of 31 in any of the three positions reads as zero, whatever value the register-read port returns for it. An add with the accumulator index at 31 therefore yields the bare product.
- R10: A destination index of 31 keeps the write enable low for a legal instruction. The result value is still delivered.
- R11: Result-valid rises exactly 1+RESULT_REG cycles (two by default) after the instruction strobe is sampled, for one cycle per instruction. After reset, all outputs except the read indices are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr_valid | input | 1 | Instruction word is present this cycle |
| instr_word | input | 32 | Three-source multiply instruction |
| rf_idx_n | output | IDX_W | Read index of the first factor |
| rf_idx_m | output | IDX_W | Read index of the second factor |
| rf_idx_a | output | IDX_W | Read index of the accumulator |
| rf_val_n | input | DATA_W | Value read for the first factor |
| rf_val_m | input | DATA_W | Value read for the second factor |
| rf_val_a | input | DATA_W | Value read for the accumulator |
| wb_valid | output | 1 | A result for an accepted instruction is present |
| wb_en | output | 1 | Write the result to the destination register |
| wb_idx | output | IDX_W | Destination register index |
| wb_data | output | DATA_W | Result value |
| illegal | output | 1 | The accepted instruction had an illegal encoding |

## Verification
The read indices are combinational, so the bench checks them one time step after it drives a word on a falling edge. The operand values are captured on the next rising edge and the result register loads on the edge after that. All write-back outputs are therefore due two rising edges after the strobe. The bench looks for result-valid still low at the falling edge in between and then compares every write-back output at the second falling edge. It issues each instruction alone, so each result can only come from that one instruction.

// File: rtl/mac3_pkg.sv
package mac3_pkg;

   localparam int INSN_W = 32;
   localparam int OPC_W  = 7;

   // Fixed class pattern in bits 28:24 of the instruction word.
   localparam logic [4:0] CLASS_PAT = 5'b11011;

   // Operation code values (size:op54:op31:sub).
   localparam logic [OPC_W-1:0] OPC_MADD_W  = 7'h00;
   localparam logic [OPC_W-1:0] OPC_MSUB_W  = 7'h01;
   localparam logic [OPC_W-1:0] OPC_MADD_X  = 7'h40;
   localparam logic [OPC_W-1:0] OPC_MSUB_X  = 7'h41;
   localparam logic [OPC_W-1:0] OPC_SWADD   = 7'h42;
   localparam logic [OPC_W-1:0] OPC_SWSUB   = 7'h43;
   localparam logic [OPC_W-1:0] OPC_SHIGH   = 7'h44;
   localparam logic [OPC_W-1:0] OPC_UWADD   = 7'h4A;
   localparam logic [OPC_W-1:0] OPC_UWSUB   = 7'h4B;
   localparam logic [OPC_W-1:0] OPC_UHIGH   = 7'h4C;

   typedef struct packed {
      logic legal;   // word is a member of the legal set
      logic sub;     // accumulator minus product
      logic high;    // upper half of the double-width product
      logic signd;   // factors are treated as signed
      logic widen;   // factors are the extended low halves
      logic full;    // keep all DATA_W result bits
   } mac3_ctrl_t;

   function automatic logic opc_is_legal(input logic [OPC_W-1:0] opc);
      logic ok;
      case (opc)
         OPC_MADD_W, OPC_MSUB_W, OPC_MADD_X, OPC_MSUB_X,
         OPC_SWADD, OPC_SWSUB, OPC_SHIGH,
         OPC_UWADD, OPC_UWSUB, OPC_UHIGH: ok = 1'b1;
         default:                         ok = 1'b0;
      endcase
      return ok;
   endfunction

endpackage

// File: rtl/mac3_decode.sv
module mac3_decode
   import mac3_pkg::*;
#(
   parameter int IDX_W = 5
) (
   input  logic [INSN_W-1:0] word,
   output logic [IDX_W-1:0]  idx_d,
   output logic [IDX_W-1:0]  idx_n,
   output logic [IDX_W-1:0]  idx_a,
   output logic [IDX_W-1:0]  idx_m,
   output mac3_ctrl_t        ctrl
);

   logic [OPC_W-1:0] opc;
   logic             class_ok;

   assign idx_d = word[4:0];
   assign idx_n = word[9:5];
   assign idx_a = word[14:10];
   assign idx_m = word[20:16];

   assign opc      = {word[31], word[30:29], word[23:21], word[15]};
   assign class_ok = (word[28:24] == CLASS_PAT);

   always_comb begin
      ctrl       = '0;
      ctrl.legal = class_ok && opc_is_legal(opc);
      ctrl.sub   = opc[0];
      ctrl.high  = opc[2];
      ctrl.full  = opc[6];
      ctrl.signd = (opc == OPC_SWADD) || (opc == OPC_SWSUB) ||
                   (opc == OPC_SHIGH);
      ctrl.widen = (opc == OPC_SWADD) || (opc == OPC_SWSUB) ||
                   (opc == OPC_UWADD) || (opc == OPC_UWSUB);
   end

endmodule

// File: rtl/mac3_opsel.sv
module mac3_opsel
   import mac3_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int IDX_W  = 5
) (
   input  logic [IDX_W-1:0]  idx_n,
   input  logic [IDX_W-1:0]  idx_m,
   input  logic [IDX_W-1:0]  idx_a,
   input  logic [DATA_W-1:0] val_n,
   input  logic [DATA_W-1:0] val_m,
   input  logic [DATA_W-1:0] val_a,
   input  mac3_ctrl_t        ctrl,
   output logic [DATA_W:0]   fac_n,
   output logic [DATA_W:0]   fac_m,
   output logic [DATA_W-1:0] acc
);

   localparam int HALF_W = DATA_W / 2;
   localparam logic [IDX_W-1:0] ZERO_IDX = '1;

   logic [1:0][IDX_W-1:0]  f_idx;
   logic [1:0][DATA_W-1:0] f_raw;
   logic [1:0][DATA_W:0]   f_out;

   assign f_idx = {idx_m, idx_n};
   assign f_raw = {val_m, val_n};

   for (genvar g = 0; g < 2; g++) begin : g_fac
      logic [DATA_W-1:0] src;
      logic [DATA_W-1:0] shaped;
      always_comb begin
         src = (f_idx[g] == ZERO_IDX) ? '0 : f_raw[g];
         if (ctrl.widen) begin
            if (ctrl.signd)
               shaped = {{HALF_W{src[HALF_W-1]}}, src[HALF_W-1:0]};
            else
               shaped = {{HALF_W{1'b0}}, src[HALF_W-1:0]};
         end else begin
            shaped = src;
         end
         f_out[g] = {ctrl.signd & shaped[DATA_W-1], shaped};
      end
   end

   assign fac_n = f_out[0];
   assign fac_m = f_out[1];
   assign acc   = (idx_a == ZERO_IDX) ? '0 : val_a;

endmodule

// File: rtl/mac3_datapath.sv
module mac3_datapath
   import mac3_pkg::*;
#(
   parameter int DATA_W = 64
) (
   input  logic [DATA_W:0]   fac_n,
   input  logic [DATA_W:0]   fac_m,
   input  logic [DATA_W-1:0] acc,
   input  mac3_ctrl_t        ctrl,
   output logic [DATA_W-1:0] result
);

   localparam int HALF_W = DATA_W / 2;
   localparam int PROD_W = 2 * DATA_W + 2;

   logic signed [PROD_W-1:0] prod;
   logic [DATA_W-1:0]        prod_lo;
   logic [DATA_W-1:0]        prod_hi;
   logic [DATA_W-1:0]        accum;
   logic [DATA_W-1:0]        pre;
   logic                     unused_prod_top;

   assign prod    = $signed(fac_n) * $signed(fac_m);
   assign prod_lo = prod[DATA_W-1:0];
   assign prod_hi = prod[2*DATA_W-1:DATA_W];
   assign unused_prod_top = ^prod[PROD_W-1:2*DATA_W];

   assign accum = ctrl.sub ? (acc - prod_lo) : (acc + prod_lo);
   assign pre   = ctrl.high ? prod_hi : accum;

   assign result = ctrl.full ? pre : {{(DATA_W-HALF_W){1'b0}}, pre[HALF_W-1:0]};

endmodule

// File: rtl/mac3_unit.sv
module mac3_unit
   import mac3_pkg::*;
#(
   parameter int DATA_W     = 64,
   parameter int IDX_W      = 5,
   parameter bit RESULT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              instr_valid,
   input  logic [31:0]       instr_word,
   output logic [IDX_W-1:0]  rf_idx_n,
   output logic [IDX_W-1:0]  rf_idx_m,
   output logic [IDX_W-1:0]  rf_idx_a,
   input  logic [DATA_W-1:0] rf_val_n,
   input  logic [DATA_W-1:0] rf_val_m,
   input  logic [DATA_W-1:0] rf_val_a,
   output logic              wb_valid,
   output logic              wb_en,
   output logic [IDX_W-1:0]  wb_idx,
   output logic [DATA_W-1:0] wb_data,
   output logic              illegal
);

   localparam logic [IDX_W-1:0] ZERO_IDX = '1;

   if (IDX_W != 5) begin : g_bad_idx
      $error("mac3_unit: IDX_W must be 5 to match the instruction fields");
   end
   if ((DATA_W % 2) != 0 || DATA_W < 8) begin : g_bad_data
      $error("mac3_unit: DATA_W must be even and at least 8");
   end

   // ---------------- decode and operand shaping ----------------
   logic [IDX_W-1:0]  dec_d;
   mac3_ctrl_t        dec_ctrl;
   logic [DATA_W:0]   sh_n;
   logic [DATA_W:0]   sh_m;
   logic [DATA_W-1:0] sh_a;

   mac3_decode #(.IDX_W(IDX_W)) u_dec (
      .word  (instr_word),
      .idx_d (dec_d),
      .idx_n (rf_idx_n),
      .idx_a (rf_idx_a),
      .idx_m (rf_idx_m),
      .ctrl  (dec_ctrl)
   );

   mac3_opsel #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_opsel (
      .idx_n (rf_idx_n),
      .idx_m (rf_idx_m),
      .idx_a (rf_idx_a),
      .val_n (rf_val_n),
      .val_m (rf_val_m),
      .val_a (rf_val_a),
      .ctrl  (dec_ctrl),
      .fac_n (sh_n),
      .fac_m (sh_m),
      .acc   (sh_a)
   );

   // ---------------- stage 1: operand capture ----------------
   logic              s1_valid;
   mac3_ctrl_t        s1_ctrl;
   logic [IDX_W-1:0]  s1_d;
   logic [DATA_W:0]   s1_n;
   logic [DATA_W:0]   s1_m;
   logic [DATA_W-1:0] s1_a;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_valid <= 1'b0;
         s1_ctrl  <= '0;
         s1_d     <= '0;
         s1_n     <= '0;
         s1_m     <= '0;
         s1_a     <= '0;
      end else begin
         s1_valid <= instr_valid;
         if (instr_valid) begin
            s1_ctrl <= dec_ctrl;
            s1_d    <= dec_d;
            s1_n    <= sh_n;
            s1_m    <= sh_m;
            s1_a    <= sh_a;
         end
      end
   end

   // ---------------- arithmetic ----------------
   logic [DATA_W-1:0] dp_res;

   mac3_datapath #(.DATA_W(DATA_W)) u_dp (
      .fac_n  (s1_n),
      .fac_m  (s1_m),
      .acc    (s1_a),
      .ctrl   (s1_ctrl),
      .result (dp_res)
   );

   logic c_valid;
   logic c_en;
   logic c_ill;

   assign c_valid = s1_valid;
   assign c_en    = s1_valid && s1_ctrl.legal && (s1_d != ZERO_IDX);
   assign c_ill   = s1_valid && !s1_ctrl.legal;

   // ---------------- optional result register ----------------
   if (RESULT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            wb_valid <= 1'b0;
            wb_en    <= 1'b0;
            illegal  <= 1'b0;
            wb_idx   <= '0;
            wb_data  <= '0;
         end else begin
            wb_valid <= c_valid;
            wb_en    <= c_en;
            illegal  <= c_ill;
            if (c_valid) begin
               wb_idx  <= s1_d;
               wb_data <= dp_res;
            end
         end
      end
   end else begin : g_comb
      assign wb_valid = c_valid;
      assign wb_en    = c_en;
      assign illegal  = c_ill;
      assign wb_idx   = s1_d;
      assign wb_data  = dp_res;
   end

endmodule

// File: rtl/mac3_unit_chk.sv
module mac3_unit_chk #(
   parameter int IDX_W      = 5,
   parameter int HALF_W     = 32,
   parameter bit RESULT_REG = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              instr_valid,
   input logic              word_sf,
   input logic [4:0]        word_pat,
   input logic [4:0]        word_rd,
   input logic              wb_valid,
   input logic              wb_en,
   input logic              illegal,
   input logic [IDX_W-1:0]  wb_idx,
   input logic [HALF_W-1:0] wb_upper
);

   localparam int LAT = 1 + int'(RESULT_REG);

   logic [LAT-1:0] v_q;
   logic [LAT-1:0] sf_q;
   logic [LAT-1:0] bad_q;
   logic [LAT-1:0] d31_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_q   <= '0;
         sf_q  <= '0;
         bad_q <= '0;
         d31_q <= '0;
      end else begin
         v_q[0]   <= instr_valid;
         sf_q[0]  <= word_sf;
         bad_q[0] <= (word_pat != 5'b11011);
         d31_q[0] <= (word_rd == 5'd31);
         for (int i = 1; i < LAT; i++) begin
            v_q[i]   <= v_q[i-1];
            sf_q[i]  <= sf_q[i-1];
            bad_q[i] <= bad_q[i-1];
            d31_q[i] <= d31_q[i-1];
         end
      end
   end

   // R11
   latency_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid == v_q[LAT-1]);

   // R2
   flag_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> !wb_en);

   // R2
   flag_qualified_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_en || illegal) |-> wb_valid);

   // R3
   bad_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (v_q[LAT-1] && bad_q[LAT-1]) |-> illegal);

   // R10
   zero_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (v_q[LAT-1] && d31_q[LAT-1]) |-> !wb_en);

   // R10
   dest_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en |-> (wb_idx != '1));

   // R5
   narrow_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_valid && !illegal && !sf_q[LAT-1]) |-> (wb_upper == '0));

endmodule

bind mac3_unit mac3_unit_chk #(
   .IDX_W      (IDX_W),
   .HALF_W     (DATA_W - DATA_W / 2),
   .RESULT_REG (RESULT_REG)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .instr_valid (instr_valid),
   .word_sf     (instr_word[31]),
   .word_pat    (instr_word[28:24]),
   .word_rd     (instr_word[4:0]),
   .wb_valid    (wb_valid),
   .wb_en       (wb_en),
   .illegal     (illegal),
   .wb_idx      (wb_idx),
   .wb_upper    (wb_data[DATA_W-1:DATA_W/2])
);

// File: tb/sim_mac3_unit.sv
`timescale 1ns/1ps
module sim_mac3_unit;

   localparam int W = 64;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          instr_valid = 1'b0;
   logic [31:0]   instr_word = '0;
   logic [4:0]    rf_idx_n, rf_idx_m, rf_idx_a;
   logic [W-1:0]  rf_val_n, rf_val_m, rf_val_a;
   logic          wb_valid, wb_en, illegal;
   logic [4:0]    wb_idx;
   logic [W-1:0]  wb_data;

   logic [W-1:0]  regs [32];
   int            n_checks = 0;
   int            n_errors = 0;
   bit            done = 1'b0;

   always #2 clk = ~clk;

   assign rf_val_n = regs[rf_idx_n];
   assign rf_val_m = regs[rf_idx_m];
   assign rf_val_a = regs[rf_idx_a];

   mac3_unit u0 (
      .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_word(instr_word),
      .rf_idx_n(rf_idx_n), .rf_idx_m(rf_idx_m), .rf_idx_a(rf_idx_a),
      .rf_val_n(rf_val_n), .rf_val_m(rf_val_m), .rf_val_a(rf_val_a),
      .wb_valid(wb_valid), .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data),
      .illegal(illegal)
   );

   task automatic chk(input bit ok, input string req, input logic [W-1:0] act,
                      input logic [W-1:0] exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] mk(input logic [6:0] opc, input logic [4:0] pat,
                                      input logic [4:0] rm, ra, rn, rd);
      return {opc[6], opc[5:4], pat, opc[3:1], rm, opc[0], ra, rn, rd};
   endfunction

   function automatic logic [W-1:0] rd_zero(input logic [4:0] i);
      return (i == 5'd31) ? '0 : regs[i];
   endfunction

   function automatic string tag_of(input logic [6:0] opc);
      case (opc)
         7'h00, 7'h01: return "R5";
         7'h40, 7'h41: return "R4";
         7'h42, 7'h43: return "R6";
         7'h4A, 7'h4B: return "R7";
         7'h44, 7'h4C: return "R8";
         default:      return "R2";
      endcase
   endfunction

   // Returns {illegal, write enable, data} per the requirements.
   function automatic logic [W+1:0] model(input logic [31:0] w);
      logic [6:0]   opc;
      logic         ok;
      logic [W-1:0] a, b, c, x, y, r;
      logic [127:0] wide;
      opc = {w[31], w[30:29], w[23:21], w[15]};
      a = rd_zero(w[9:5]);
      b = rd_zero(w[20:16]);
      c = rd_zero(w[14:10]);
      ok = (w[28:24] == 5'b11011);
      r = '0;
      case (opc)
         7'h00, 7'h01, 7'h40, 7'h41: begin x = a; y = b; end
         7'h42, 7'h43: begin
            x = {{32{a[31]}}, a[31:0]}; y = {{32{b[31]}}, b[31:0]};
         end
         7'h4A, 7'h4B: begin x = {32'h0, a[31:0]}; y = {32'h0, b[31:0]}; end
         default: begin x = a; y = b; end
      endcase
      case (opc)
         7'h44: begin
            wide = 128'($signed({{64{a[63]}}, a}) * $signed({{64{b[63]}}, b}));
            r = wide[127:64];
         end
         7'h4C: begin
            wide = {64'h0, a} * {64'h0, b};
            r = wide[127:64];
         end
         7'h00, 7'h40, 7'h42, 7'h4A: r = c + x * y;
         7'h01, 7'h41, 7'h43, 7'h4B: r = c - x * y;
         default: ok = 1'b0;
      endcase
      if (!opc[6]) r = {32'h0, r[31:0]};
      return {!ok, ok && (w[4:0] != 5'd31), r};
   endfunction

   task automatic run_op(input logic [31:0] w, input string tag);
      logic [W+1:0] e;
      @(negedge clk);
      instr_word  = w;
      instr_valid = 1'b1;
      #1;
      e = model(w);
      // R1: read indices follow the word combinationally
      chk(rf_idx_n == w[9:5] && rf_idx_m == w[20:16] && rf_idx_a == w[14:10],
          "R1", W'({rf_idx_n, rf_idx_m, rf_idx_a}), W'({w[9:5], w[20:16], w[14:10]}));
      @(negedge clk);
      instr_valid = 1'b0;
      chk(wb_valid == 1'b0, "R11 early", W'(wb_valid), 0);
      @(negedge clk);
      chk(wb_valid == 1'b1, "R11 due", W'(wb_valid), 1);
      chk(illegal == e[W+1], tag, W'(illegal), W'(e[W+1]));
      chk(wb_en == e[W], tag, W'(wb_en), W'(e[W]));
      chk(wb_idx == w[4:0], "R1 dest", W'(wb_idx), W'(w[4:0]));
      if (!e[W+1]) chk(wb_data == e[W-1:0], tag, wb_data, e[W-1:0]);
   endtask

   function automatic logic [W-1:0] pick_val();
      case ($urandom % 7)
         0: return 64'h8000_0000_0000_0000;
         1: return '1;
         2: return 64'h7FFF_FFFF_FFFF_FFFF;
         3: return 64'h0000_0000_8000_0000;
         4: return {$urandom, 32'h8000_0000};
         default: return {$urandom, $urandom};
      endcase
   endfunction

   function automatic logic [6:0] legal_code(input int k);
      case (k)
         0: return 7'h00;  1: return 7'h01;  2: return 7'h40;  3: return 7'h41;
         4: return 7'h42;  5: return 7'h43;  6: return 7'h44;  7: return 7'h4A;
         8: return 7'h4B;  default: return 7'h4C;
      endcase
   endfunction

   initial begin
      #(200000 * 4);
      if (!done) begin
         n_errors++;
         n_checks++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   initial begin
      int seed;
      seed = $urandom(32'd20240611);
      for (int i = 0; i < 32; i++) regs[i] = {$urandom, $urandom};
      regs[31] = 64'hDEAD_BEEF_0BAD_F00D;

      repeat (3) @(negedge clk);
      // R11: reset state
      chk(wb_valid == 0 && wb_en == 0 && illegal == 0 && wb_data == 0, "R11 reset",
          wb_data, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R8: most-negative and all-ones operands in the high forms
      regs[1] = 64'h8000_0000_0000_0000; regs[2] = 64'h8000_0000_0000_0000;
      regs[3] = '1; regs[4] = 64'h1234;
      run_op(mk(7'h44, 5'b11011, 5'd2, 5'd4, 5'd1, 5'd5), "R8");
      run_op(mk(7'h4C, 5'b11011, 5'd3, 5'd4, 5'd3, 5'd5), "R8");
      run_op(mk(7'h44, 5'b11011, 5'd3, 5'd4, 5'd3, 5'd5), "R8");
      // R6 / R7: low halves of -1 with a positive factor
      regs[6] = 64'hFFFF_FFFF_FFFF_FFFF; regs[7] = 64'h5555_5555_0000_0003;
      run_op(mk(7'h42, 5'b11011, 5'd7, 5'd4, 5'd6, 5'd8), "R6");
      run_op(mk(7'h4B, 5'b11011, 5'd7, 5'd4, 5'd6, 5'd8), "R7");
      // R9: accumulator index 31 gives the bare product; factor 31 reads zero
      run_op(mk(7'h40, 5'b11011, 5'd7, 5'd31, 5'd6, 5'd9), "R9");
      run_op(mk(7'h41, 5'b11011, 5'd31, 5'd4, 5'd6, 5'd9), "R9");
      run_op(mk(7'h40, 5'b11011, 5'd31, 5'd31, 5'd31, 5'd9), "R9");
      // R10: destination 31 never writes
      run_op(mk(7'h40, 5'b11011, 5'd7, 5'd4, 5'd6, 5'd31), "R10");
      // R3: class pattern mismatch with an otherwise legal code
      run_op(mk(7'h40, 5'b11010, 5'd7, 5'd4, 5'd6, 5'd9), "R3");
      run_op(mk(7'h00, 5'b01011, 5'd7, 5'd4, 5'd6, 5'd9), "R3");
      // R2: codes outside the legal set
      run_op(mk(7'h02, 5'b11011, 5'd7, 5'd4, 5'd6, 5'd9), "R2");
      run_op(mk(7'h45, 5'b11011, 5'd7, 5'd4, 5'd6, 5'd9), "R2");
      run_op(mk(7'h04, 5'b11011, 5'd7, 5'd4, 5'd6, 5'd9), "R2");
      // R5: narrow subtract that wraps
      run_op(mk(7'h01, 5'b11011, 5'd7, 5'd4, 5'd6, 5'd10), "R5");

      // Every legal code once, then constrained random mix
      for (int k = 0; k < 10; k++)
         run_op(mk(legal_code(k), 5'b11011, 5'd2, 5'd6, 5'd1, 5'd11),
                tag_of(legal_code(k)));
      for (int n = 0; n < 400; n++) begin
         logic [6:0] opc;
         logic [4:0] pat, rm, ra, rn, rd;
         opc = (($urandom % 8) != 0) ? legal_code($urandom % 10) : 7'($urandom);
         pat = (($urandom % 16) != 0) ? 5'b11011 : 5'($urandom);
         rm = 5'($urandom); ra = 5'($urandom); rn = 5'($urandom); rd = 5'($urandom);
         if (rm != 5'd31) regs[rm] = pick_val();
         if (ra != 5'd31) regs[ra] = pick_val();
         if (rn != 5'd31) regs[rn] = pick_val();
         run_op(mk(opc, pat, rm, ra, rn, rd),
                (pat != 5'b11011) ? "R3" : tag_of(opc));
      end

      @(negedge clk);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule